// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor with Overflow Flag

This block adds or subtracts two signed operands held in sign-magnitude form. The top bit of each word is the sign, where 1 means negative. The remaining bits hold the unsigned magnitude. The signs of the two operands decide the operation. When the signs agree, the magnitudes are added and the common sign is kept. When they disagree, the two magnitudes are compared, the smaller is taken from the larger, and the result takes the sign of the operand with the larger magnitude. A subtract control flips the sign of the second operand before this choice, so A minus B is computed as A plus (-B).

The result word and the overflow flag are registered. They appear on the outputs after the first rising clock edge that follows a change of the inputs. A like-sign sum too large for the magnitude field is not saturated. The flag goes high, and the word carries the original sign above the low magnitude bits of the wrapped sum. Zero always leaves the block as the all-zero word, except on the overflow path, whose output is fixed by the rule above. Operands with sign 1 and zero magnitude are accepted and treated as zero.

Top module: `sm_adder`

## Requirements
- R1: When the effective signs agree and the magnitude sum fits in WIDTH-1 bits, the output magnitude is that sum and the output sign is the common sign, with overflow low (for example 0x85 + 0x83 gives 0x88).
- R2: When the effective signs differ, the output magnitude is the larger magnitude minus the smaller, and the output sign is the sign of the larger-magnitude operand (0x69 + 0xAC gives 0x3D).
- R3: When the effective signs agree and the magnitude sum carries out of WIDTH-1 bits, overflow is 1. The output is the common sign followed by the low WIDTH-1 bits of the sum, and the sign is kept even when those bits are all zero (0xFF + 0x81 gives 0x80 with overflow).
- R4: Overflow is 0 whenever the effective signs differ.
- R5: Equal magnitudes with differing effective signs give the word 0x00, never 0x80.
- R6: With sub_i = 1, bit WIDTH-1 of b_i is inverted before the operation (0x05 minus 0x07 gives 0x82; 0x7F minus 0x81 overflows to 0x00).
- R7: An operand 0x80 behaves exactly as 0x00 in every operation (0x80 + 0x85 gives 0x85; 0x80 + 0x05 gives 0x05).
- R8: A like-sign result whose untruncated magnitude is zero is output as 0x00 with overflow low (0x80 + 0x80 gives 0x00).
- R9: A synchronous active-high reset clears sum_o and ovf_o to 0. Otherwise each output reflects the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | Operand A, sign in top bit |
| b_i | input | WIDTH | Operand B, sign in top bit |
| sub_i | input | 1 | 1 to subtract B from A |
| sum_o | output | WIDTH | Registered sign-magnitude result |
| ovf_o | output | 1 | Registered like-sign overflow flag |

## Verification
Subtraction and overflow can act in the same cycle. A subtract request can turn operands with unlike signs into a like-sign pair whose magnitude sum carries, for example 0x7F minus 0x81. The bench applies such pairs directly, and random vectors with sub_i toggled produce more of them. Each result is compared against an integer model that negates B first and then applies the overflow rule. Zero normalisation and truncation to a zero magnitude can also meet: the overflow case 0xFF + 0x81 must keep sign 1, while 0x80 + 0x80 must clear it, and both are checked.

// File: rtl/sm_adder_pkg.sv
package sm_adder_pkg;
  // Selects which magnitude datapath feeds the result register.
  typedef enum logic {
    PATH_SUM  = 1'b0,
    PATH_DIFF = 1'b1
  } sm_path_e;

  typedef struct packed {
    logic sign;
    logic ovf;
  } sm_flags_t;
endpackage

// File: rtl/sm_operand_split.sv
module sm_operand_split #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic             flip_i,
  output logic             sign_o,
  output logic [WIDTH-2:0] mag_o
);
  localparam int MAG_W = WIDTH - 1;

  // The effective sign includes the optional subtract inversion.
  assign sign_o = word_i[MAG_W] ^ flip_i;
  assign mag_o  = word_i[MAG_W-1:0];
endmodule

// File: rtl/sm_mag_unit.sv
module sm_mag_unit #(
  parameter int MAG_W      = 7,
  parameter bit BORROW_CMP = 1'b1
) (
  input  logic [MAG_W-1:0] a_mag_i,
  input  logic [MAG_W-1:0] b_mag_i,
  output logic [MAG_W-1:0] sum_o,
  output logic             carry_o,
  output logic [MAG_W-1:0] diff_o,
  output logic             a_gt_o,
  output logic             b_gt_o
);
  logic [MAG_W:0]   wide_sum;
  logic [MAG_W:0]   a_minus_b;
  logic [MAG_W-1:0] b_minus_a;
  logic             a_lt_b;
  logic             mags_eq;

  assign wide_sum  = {1'b0, a_mag_i} + {1'b0, b_mag_i};
  assign sum_o     = wide_sum[MAG_W-1:0];
  assign carry_o   = wide_sum[MAG_W];

  assign a_minus_b = {1'b0, a_mag_i} - {1'b0, b_mag_i};
  assign b_minus_a = b_mag_i - a_mag_i;
  assign mags_eq   = (a_mag_i == b_mag_i);

  // The parameter chooses how the magnitude comparison is made.
  generate
    if (BORROW_CMP) begin : g_borrow_cmp
      // Reuse the borrow of the A-B subtractor as the comparison.
      assign a_lt_b = a_minus_b[MAG_W];
    end else begin : g_direct_cmp
      assign a_lt_b = (a_mag_i < b_mag_i);
    end
  endgenerate

  assign a_gt_o = !a_lt_b && !mags_eq;
  assign b_gt_o = a_lt_b;
  assign diff_o = a_lt_b ? b_minus_a : a_minus_b[MAG_W-1:0];
endmodule

// File: rtl/sm_adder.sv
module sm_adder
  import sm_adder_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit BORROW_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  localparam int MAG_W   = WIDTH - 1;
  localparam int N_OPS   = 2;

  logic [WIDTH-1:0] op_word [N_OPS];
  logic [N_OPS-1:0] op_flip;
  logic [N_OPS-1:0] op_sign;
  logic [MAG_W-1:0] op_mag  [N_OPS];

  assign op_word[0] = a_i;
  assign op_word[1] = b_i;
  assign op_flip    = {sub_i, 1'b0};

  generate
    for (genvar g = 0; g < N_OPS; g++) begin : g_split
      sm_operand_split #(.WIDTH(WIDTH)) u_split (
        .word_i (op_word[g]),
        .flip_i (op_flip[g]),
        .sign_o (op_sign[g]),
        .mag_o  (op_mag[g])
      );
    end
  endgenerate

  logic [MAG_W-1:0] m_sum;
  logic             m_carry;
  logic [MAG_W-1:0] m_diff;
  logic             a_gt;
  logic             b_gt;

  sm_mag_unit #(.MAG_W(MAG_W), .BORROW_CMP(BORROW_CMP)) u_mag (
    .a_mag_i (op_mag[0]),
    .b_mag_i (op_mag[1]),
    .sum_o   (m_sum),
    .carry_o (m_carry),
    .diff_o  (m_diff),
    .a_gt_o  (a_gt),
    .b_gt_o  (b_gt)
  );

  sm_path_e         path;
  sm_flags_t        nxt_flags;
  logic [MAG_W-1:0] nxt_mag;

  always_comb begin
    path = (op_sign[0] == op_sign[1]) ? PATH_SUM : PATH_DIFF;
    unique case (path)
      PATH_SUM: begin
        nxt_mag       = m_sum;
        nxt_flags.ovf = m_carry;
        // Keep the sign on carry; otherwise a zero sum becomes +0.
        nxt_flags.sign = op_sign[0] & (m_carry | (|m_sum));
      end
      default: begin
        nxt_mag        = m_diff;
        nxt_flags.ovf  = 1'b0;
        nxt_flags.sign = (a_gt & op_sign[0]) | (b_gt & op_sign[1]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      sum_o <= {nxt_flags.sign, nxt_mag};
      ovf_o <= nxt_flags.ovf;
    end
  end

  // R4: unlike effective signs never flag overflow.
  assert_unlike_no_ovf_R4: assert property (@(posedge clk) disable iff (rst)
    (a_i[MAG_W] != (b_i[MAG_W] ^ sub_i)) |=> !ovf_o);

  // R5, R8: a zero magnitude without overflow is never negative.
  assert_no_neg_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (sum_o[MAG_W-1:0] == '0 && !ovf_o) |-> !sum_o[MAG_W]);

  // R3: an overflowing result keeps the sign of operand A.
  assert_ovf_keeps_sign_R3: assert property (@(posedge clk) disable iff (rst)
    (a_i[MAG_W] == (b_i[MAG_W] ^ sub_i)) |=> (!ovf_o || sum_o[MAG_W] == $past(a_i[MAG_W])));

  // R1: a like-sign result carries the common sign unless it is zero.
  assert_like_sign_R1: assert property (@(posedge clk) disable iff (rst)
    (a_i[MAG_W] == (b_i[MAG_W] ^ sub_i)) |=> (sum_o[MAG_W] == $past(a_i[MAG_W]) || sum_o == '0));

  // R6: subtracting an operand from itself yields positive zero.
  assert_self_sub_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (sub_i && a_i == b_i) |=> (sum_o == '0 && !ovf_o));

  // R2: the difference magnitude never exceeds either operand's larger magnitude.
  assert_diff_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    (path == PATH_DIFF) |-> (m_diff <= op_mag[0] || m_diff <= op_mag[1]));
endmodule

// File: tb/sm_adder_test.sv
module sm_adder_test;
  localparam int W     = 8;
  localparam int MW    = W - 1;
  localparam int MAXM  = (1 << MW) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         sub_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         ovf_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sm_adder #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .sum_o(sum_o), .ovf_o(ovf_o)
  );

  // Integer model: returns {ovf, word}.
  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub);
    int ma, mb, va, vb, r, t;
    logic sa, sb;
    logic [W:0] res;
    ma = int'(a[MW-1:0]);
    mb = int'(b[MW-1:0]);
    sa = a[MW];
    sb = b[MW] ^ sub;
    if (sa == sb && ma + mb > MAXM) begin
      t = ma + mb - (MAXM + 1);
      res = {1'b1, sa, t[MW-1:0]};
    end else begin
      va = sa ? -ma : ma;
      vb = sb ? -mb : mb;
      r  = va + vb;
      if (r < 0) begin
        t = -r;
        res = {1'b0, 1'b1, t[MW-1:0]};
      end else begin
        res = {1'b0, 1'b0, r[MW-1:0]};
      end
    end
    return res;
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub, input string req);
    logic [W:0] exp;
    @(negedge clk);
    a_i = a; b_i = b; sub_i = sub;
    exp = model(a, b, sub);
    @(negedge clk);
    checks++;
    if ({ovf_o, sum_o} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h sub=%b got ovf=%b sum=%h expected ovf=%b sum=%h",
               req, a, b, sub, ovf_o, sum_o, exp[W], exp[W-1:0]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [W-1:0] ra, rb;
    logic rs;
    seed = 32'h5A17;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    // R9: reset state.
    checks++;
    if (sum_o !== '0 || ovf_o !== 1'b0) begin
      errors++;
      $display("FAIL R9: got sum=%h ovf=%b expected sum=00 ovf=0", sum_o, ovf_o);
    end
    rst = 1'b0;
    apply(8'h85, 8'h83, 1'b0, "R1");
    apply(8'h14, 8'h22, 1'b0, "R1");
    apply(8'h69, 8'hAC, 1'b0, "R2");
    apply(8'h8E, 8'h7E, 1'b0, "R2");
    apply(8'hFF, 8'h81, 1'b0, "R3");
    apply(8'hE4, 8'hB2, 1'b0, "R3");
    apply(8'h7F, 8'h7F, 1'b0, "R3");
    apply(8'h85, 8'h07, 1'b0, "R4");
    apply(8'h85, 8'h05, 1'b0, "R5");
    apply(8'h33, 8'h33, 1'b1, "R6");
    apply(8'h05, 8'h07, 1'b1, "R6");
    apply(8'h7F, 8'h81, 1'b1, "R6");
    apply(8'h80, 8'h85, 1'b0, "R7");
    apply(8'h80, 8'h05, 1'b0, "R7");
    apply(8'h80, 8'h00, 1'b0, "R7");
    apply(8'h80, 8'h80, 1'b0, "R8");
    apply(8'h80, 8'h00, 1'b1, "R8");
    for (int i = 0; i < 4000; i++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      rs = 1'($urandom);
      if (i % 5 == 0) rb = {~(ra[MW] ^ rs), ra[MW-1:0]};
      apply(ra, rb, rs, "R1/R2/R3 random");
    end
    // R9: synchronous reset clears a live overflow result.
    apply(8'hFF, 8'hFF, 1'b0, "R3");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (sum_o !== '0 || ovf_o !== 1'b0) begin
      errors++;
      $display("FAIL R9: got sum=%h ovf=%b expected sum=00 ovf=0", sum_o, ovf_o);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule